// File: doc/BRIEF.md
# SDRAM Burst Write Engine

This block is the device-side write path of a synchronous DRAM. On every rising clock edge it decodes the four command pins. When it sees a write command, it stores the data word on the data inputs into a small internal column array, at the column given by the address inputs. Writes have no latency: the first word is taken on the same edge as the command. On each following edge the block takes one more word, until the selected burst length is reached. Any data that arrives after that has no effect.

The burst length is chosen at run time and latched with the write command. Columns advance upward and wrap inside the aligned block whose size is the burst length. A write command that arrives while a burst is running aborts that burst and starts a full new burst at the new column. Deselect and no-operation cycles leave a running burst untouched. Two observation outputs show whether a word is being captured on the coming edge and which column it goes to. A plain combinational read port exposes the array contents.

Top module: `sdram_wr_burst`

## Requirements
- R1: A write command is decoded on a rising edge when cs_n=0, ras_n=1, cas_n=0 and we_n=0. No other pin combination starts a burst. A read pattern (cs_n=0, ras_n=1, cas_n=0, we_n=1) writes nothing.
- R2: The word on dq on the command edge is written to the column on addr on that same edge.
- R3: bl_sel is sampled with the command: 0 gives 1 word, 1 gives 2, 2 gives 4 and 3 gives 8. After the first word, one word is written on each following edge until that count is reached.
- R4: Each subsequent column is the previous column plus one, wrapping within the aligned block of burst-length columns. For example, length 4 from column 5 writes 5, 6, 7, 4.
- R5: After a burst completes, dq values do not change the array, and wr_busy is low.
- R6: A write command during a burst stops the old burst. Its unwritten columns keep their old contents, and a full new burst starts at the new column.
- R7: Write commands on consecutive edges are legal. The first burst then writes only its first word.
- R8: Deselect (cs_n=1) and no-operation (all of ras_n, cas_n and we_n high) cycles do not stop a burst in progress.
- R9: wr_busy is high before each edge that captures a burst word. cur_col then shows the column that word goes to.
- R10: rst (synchronous, active high) ends any burst. No word is captured on a reset edge. The array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the burst state |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write enable command pin |
| addr | input | COL_W | Starting column, sampled with a write command |
| dq | input | DATA_W | Write data |
| bl_sel | input | 2 | Burst length select (1/2/4/8) |
| rd_col | input | COL_W | Column for the read port |
| rd_data | output | DATA_W | Array contents at rd_col |
| wr_busy | output | 1 | A word is captured on the coming edge |
| cur_col | output | COL_W | Column written on the coming edge |

## Verification
The assertions assume that COL_W is at least 3, so that an aligned block of eight columns exists. They also assume that pins outside the recognized command patterns only need to avoid starting a burst. The stimulus uses just four pin patterns: write, read, no-operation and deselect. It changes inputs only half a period away from the capturing edge, so each command and data word is sampled cleanly. The array is first filled with a known pattern through ordinary length-8 bursts. This lets later checks tell apart columns that were skipped after an abort, or left alone after a burst ended, from columns that were written.

// File: rtl/sdram_wr_burst.sv
module sdram_wr_burst #(
  parameter int COL_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [COL_W-1:0]  addr,
  input  logic [DATA_W-1:0] dq,
  input  logic [1:0]        bl_sel,
  input  logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_busy,
  output logic [COL_W-1:0]  cur_col
);
  localparam int DEPTH = 1 << COL_W;

  function automatic logic [COL_W-1:0] len_mask(input logic [1:0] s);
    logic [COL_W-1:0] m;
    m = '0;
    for (int i = 0; i < 3; i++)
      if (i < int'(s)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [COL_W-1:0] step_col(input logic [COL_W-1:0] c,
                                                input logic [COL_W-1:0] m);
    return (c & ~m) | ((c + 1'b1) & m);
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic              active;
  logic [2:0]        left;
  logic [COL_W-1:0]  col_q, msk_q;

  wire              is_wr   = !cs_n && ras_n && !cas_n && !we_n;
  wire [COL_W-1:0]  cmd_msk = len_mask(bl_sel);
  wire              capture = !rst && (is_wr || active);

  assign wr_busy = capture;
  assign cur_col = is_wr ? addr : col_q;
  assign rd_data = mem[rd_col];

  always_ff @(posedge clk)
    if (capture) mem[cur_col] <= dq;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      left   <= '0;
      col_q  <= '0;
      msk_q  <= '0;
    end else if (is_wr) begin
      msk_q  <= cmd_msk;
      col_q  <= step_col(addr, cmd_msk);
      active <= (bl_sel != 2'd0);
      left   <= (bl_sel == 2'd0) ? 3'd0 : cmd_msk[2:0] - 3'd1;
    end else if (active) begin
      col_q <= step_col(col_q, msk_q);
      if (left == 3'd0) active <= 1'b0;
      else              left   <= left - 3'd1;
    end
  end

  AST_SINGLE_WORD: assert property (@(posedge clk) disable iff (rst)
    (is_wr && bl_sel == 2'd0) |=> (is_wr || !wr_busy)); // R3
  AST_FIRST_STEP: assert property (@(posedge clk) disable iff (rst)
    (is_wr && bl_sel != 2'd0) |=>
      (is_wr || (wr_busy && cur_col == step_col($past(addr), $past(cmd_msk))))); // R4
  AST_STAY_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (active && !is_wr) |=>
      (is_wr || !wr_busy || cur_col[COL_W-1:3] == $past(cur_col[COL_W-1:3]))); // R4
  AST_NOP_KEEPS_BURST: assert property (@(posedge clk) disable iff (rst)
    (wr_busy && !is_wr && left != 3'd0) |=> wr_busy); // R8
  AST_RESET_STOPS: assert property (@(posedge clk)
    rst |=> (is_wr || !wr_busy)); // R10
endmodule

// File: tb/sdram_wr_burst_tb.sv
module sdram_wr_burst_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic cs_n, ras_n, cas_n, we_n;
  logic [3:0] addr, rd_col, cur_col;
  logic [7:0] dq, rd_data;
  logic [1:0] bl_sel;
  logic wr_busy;
  int nvec = 0, nbad = 0;

  always #4 clk = ~clk;

  sdram_wr_burst #(.COL_W(4), .DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .dq(dq), .bl_sel(bl_sel), .rd_col(rd_col), .rd_data(rd_data),
    .wr_busy(wr_busy), .cur_col(cur_col));

  localparam logic [1:0] NOP = 2'd0, WR = 2'd1, DES = 2'd2, RD = 2'd3;
  // {cmd, addr, dq, bl_sel, exp_busy, exp_col}
  localparam int NV = 15;
  localparam logic [20:0] VEC [NV] = '{
    {WR,  4'h5, 8'h11, 2'd2, 1'b1, 4'h5},  // R2 R4 length 4 from 5
    {NOP, 4'h0, 8'h12, 2'd0, 1'b1, 4'h6},
    {DES, 4'h0, 8'h13, 2'd0, 1'b1, 4'h7},  // R8 deselect mid-burst
    {NOP, 4'h0, 8'h14, 2'd0, 1'b1, 4'h4},  // R4 wrap
    {NOP, 4'h0, 8'h15, 2'd0, 1'b0, 4'h0},  // R5 burst over
    {WR,  4'h2, 8'h21, 2'd3, 1'b1, 4'h2},
    {NOP, 4'h0, 8'h22, 2'd0, 1'b1, 4'h3},
    {NOP, 4'h0, 8'h23, 2'd0, 1'b1, 4'h4},
    {WR,  4'h9, 8'h31, 2'd1, 1'b1, 4'h9},  // R6 abort
    {NOP, 4'h0, 8'h32, 2'd0, 1'b1, 4'h8},
    {NOP, 4'h0, 8'h33, 2'd0, 1'b0, 4'h0},
    {WR,  4'hE, 8'h41, 2'd1, 1'b1, 4'hE},  // R7 back-to-back
    {WR,  4'hB, 8'h42, 2'd0, 1'b1, 4'hB},  // R3 single word
    {RD,  4'hC, 8'h43, 2'd0, 1'b0, 4'h0},  // R1 read is not a write
    {NOP, 4'h0, 8'h44, 2'd0, 1'b0, 4'h0}
  };
  localparam logic [7:0] EXP [16] = '{
    8'hA0, 8'hA1, 8'h21, 8'h22, 8'h23, 8'h11, 8'h12, 8'h13,
    8'h32, 8'h31, 8'hAA, 8'h42, 8'hAC, 8'hAD, 8'h41, 8'hAF};

  task automatic drive(input logic [1:0] c, input logic [3:0] a,
                       input logic [7:0] d, input logic [1:0] b);
    cs_n  = (c == DES);
    ras_n = 1'b1;
    cas_n = !(c == WR || c == RD);
    we_n  = !(c == WR);
    addr = a; dq = d; bl_sel = b;
  endtask

  task automatic check(input string req, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    drive(NOP, 0, 0, 0);
    rd_col = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #2 check("R10 reset busy", wr_busy, 0);
    rst = 1'b0;
    for (int k = 0; k < 16; k++) begin     // R3 length-8 fill
      @(negedge clk);
      drive((k % 8 == 0) ? WR : NOP, 4'(k), 8'hA0 + 8'(k), 2'd3);
      #2 check("R3 fill busy", wr_busy, 1);
      check("R9 fill col", cur_col, k);
    end
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive(VEC[v][20:19], VEC[v][18:15], VEC[v][14:7], VEC[v][6:5]);
      #2 check($sformatf("R9 vec %0d busy", v), wr_busy, int'(VEC[v][4]));
      if (VEC[v][4]) check($sformatf("R9 vec %0d col", v), cur_col, int'(VEC[v][3:0]));
    end
    for (int i = 0; i < 16; i++) begin     // R2 R5 R6 R7 R1 array contents
      @(negedge clk);
      drive(NOP, 0, 8'hEE, 0);
      rd_col = 4'(i);
      #1 check($sformatf("R6 array col %0d", i), rd_data, int'(EXP[i]));
    end
    @(negedge clk);
    drive(WR, 4'h0, 8'h55, 2'd3);
    @(negedge clk);
    rst = 1'b1;
    drive(NOP, 0, 8'h66, 0);
    #2 check("R10 busy in reset", wr_busy, 0);
    @(negedge clk);
    rst = 1'b0;
    drive(NOP, 0, 8'h77, 0);
    #2 check("R10 busy after reset", wr_busy, 0);
    @(negedge clk);
    rd_col = 0; #1 check("R10 col0", rd_data, 8'h55);
    rd_col = 1; #1 check("R10 col1 not written", rd_data, 8'hA1);
    rd_col = 2; #1 check("R10 array kept", rd_data, 8'h21);
    finish_run();
  end
endmodule